// File: doc/BRIEF.md
# Configurable AND-OR Logic Array

This block is a two-level logic array whose connections are set at run time. Every input is presented twice to the first plane: once as itself and once inverted. Each product-term gate in that first plane ANDs whatever subset of these literals its connection row selects. Each output of the second plane ORs whatever subset of the product terms its own connection row selects. Because the second plane is programmable too, one product term can feed several outputs.

Both connection maps live in registers. A simple addressed port writes one full row at a time, and a plane-select bit chooses which map the row goes to. The path from `data_in` to `data_out` has no register in it, so a new input pattern reaches the outputs within the same cycle. The array is sized by three parameters: inputs, product terms and outputs. The defaults give 4 inputs, 6 product terms and 3 outputs.

Top module: `lar_top`

## Requirements
- R1: In an AND-plane row, bit 2i connects the true literal of input i and bit 2i+1 connects its complement. A product term is the AND of every literal its row connects.
- R2: In OR-plane row o, bit p connects product term p. Output o is the OR of every connected product term, and one product term may be connected to several outputs at once.
- R3: A product term whose AND-plane row is all zero evaluates to 1.
- R4: An output whose OR-plane row is all zero evaluates to 0.
- R5: A product term that connects both the true and the complemented literal of the same input evaluates to 0 for every input pattern.
- R6: A row is written when `cfg_we` is 1 at a rising edge. `cfg_plane`=0 selects the AND plane and 1 selects the OR plane, and `cfg_row` selects the row. The new connections show at the outputs after that edge. When `cfg_we` is 0, no connection changes, whatever the other configuration inputs carry.
- R7: A write whose row is at or beyond the row count of the selected plane changes nothing. `cfg_data` bits above the selected plane's row width are ignored: the AND plane uses the low 2·N_IN bits and the OR plane uses the low N_PT bits.
- R8: A synchronous active-high `rst` clears every connection bit, so every output reads 0 afterwards.
- R9: The default size can be set up to give out0 = A'B' + AC' from product terms A'B', AC', B, BC' and AC, where A, B and C are inputs 0, 1 and 2.
- R10: `data_out` follows a change on `data_in` within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset; clears both maps |
| cfg_we | input | 1 | Row write strobe |
| cfg_plane | input | 1 | 0 = AND plane, 1 = OR plane |
| cfg_row | input | ROW_W | Row address within the selected plane |
| cfg_data | input | ROW_BITS | Connection bits for the addressed row |
| data_in | input | N_IN | Logic inputs |
| data_out | output | N_OUT | Logic outputs |

## Verification
Every input combination is applied against five kinds of connection maps, and each map exposes a different fault:
- The cleared map after reset shows whether an output with nothing connected falls back to 0.
- The hand-built three-output map, with one term shared by two outputs, shows whether literal polarity and term sharing are right.
- Single rows that are empty or self-contradicting separate the constant-1 term from the constant-0 term.
- Writes with the strobe low, with rows out of range, and with stray high data bits show whether anything leaks into the stored maps.
- Random maps then cover the general sum-of-products behaviour.

// File: rtl/lar_pkg.sv
package lar_pkg;
  typedef enum logic {
    PLANE_AND = 1'b0,
    PLANE_OR  = 1'b1
  } plane_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lar_lit_gen.sv
module lar_lit_gen #(
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0]   sig_i,
  output logic [2*N_IN-1:0] lit_o
);
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit_o[2*i]   = sig_i[i];
    assign lit_o[2*i+1] = ~sig_i[i];
  end
endmodule

// File: rtl/lar_cfg_bank.sv
module lar_cfg_bank #(
  parameter int ROWS   = 6,
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_row,
  input  logic [WIDTH-1:0]            wr_bits,
  output logic [ROWS-1:0][WIDTH-1:0]  rows_o
);
  logic [ROWS-1:0][WIDTH-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
    end else if (wr_en && (int'(wr_row) < ROWS)) begin
      bank_q[wr_row] <= wr_bits;
    end
  end

  assign rows_o = bank_q;
endmodule

// File: rtl/lar_and_plane.sv
module lar_and_plane #(
  parameter int N_LIT = 8,
  parameter int N_PT  = 6
) (
  input  logic [N_LIT-1:0]            lit_i,
  input  logic [N_PT-1:0][N_LIT-1:0]  conn_i,
  output logic [N_PT-1:0]             term_o
);
  for (genvar p = 0; p < N_PT; p++) begin : g_term
    // a literal that is not connected reads as 1 for this gate
    assign term_o[p] = &(lit_i | ~conn_i[p]);
  end
endmodule

// File: rtl/lar_or_plane.sv
module lar_or_plane #(
  parameter int N_PT  = 6,
  parameter int N_OUT = 3
) (
  input  logic [N_PT-1:0]             term_i,
  input  logic [N_OUT-1:0][N_PT-1:0]  conn_i,
  output logic [N_OUT-1:0]            sum_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign sum_o[o] = |(term_i & conn_i[o]);
  end
endmodule

// File: rtl/lar_top.sv
module lar_top
  import lar_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_PT  = 6,
  parameter int N_OUT = 3,
  localparam int AND_W    = 2 * N_IN,
  localparam int ROW_BITS = imax(AND_W, N_PT),
  localparam int ROWS_MAX = imax(N_PT, N_OUT),
  localparam int ROW_W    = (ROWS_MAX > 1) ? $clog2(ROWS_MAX) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_plane,
  input  logic [ROW_W-1:0]    cfg_row,
  input  logic [ROW_BITS-1:0] cfg_data,
  input  logic [N_IN-1:0]     data_in,
  output logic [N_OUT-1:0]    data_out
);
  logic [AND_W-1:0]             lits;
  logic [N_PT-1:0][AND_W-1:0]   and_mask;
  logic [N_OUT-1:0][N_PT-1:0]   or_mask;
  logic [N_PT-1:0]              pt_vec;
  logic                         we_and;
  logic                         we_or;

  assign we_and = cfg_we && (plane_e'(cfg_plane) == PLANE_AND);
  assign we_or  = cfg_we && (plane_e'(cfg_plane) == PLANE_OR);

  lar_cfg_bank #(.ROWS(N_PT), .WIDTH(AND_W), .ADDR_W(ROW_W)) u_and_bank (
    .clk(clk), .rst(rst), .wr_en(we_and), .wr_row(cfg_row),
    .wr_bits(cfg_data[AND_W-1:0]), .rows_o(and_mask)
  );

  lar_cfg_bank #(.ROWS(N_OUT), .WIDTH(N_PT), .ADDR_W(ROW_W)) u_or_bank (
    .clk(clk), .rst(rst), .wr_en(we_or), .wr_row(cfg_row),
    .wr_bits(cfg_data[N_PT-1:0]), .rows_o(or_mask)
  );

  lar_lit_gen #(.N_IN(N_IN)) u_lit (
    .sig_i(data_in), .lit_o(lits)
  );

  lar_and_plane #(.N_LIT(AND_W), .N_PT(N_PT)) u_and (
    .lit_i(lits), .conn_i(and_mask), .term_o(pt_vec)
  );

  lar_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .term_i(pt_vec), .conn_i(or_mask), .sum_o(data_out)
  );
endmodule

// File: rtl/lar_checker.sv
module lar_checker #(
  parameter int N_IN     = 4,
  parameter int N_PT     = 6,
  parameter int N_OUT    = 3,
  parameter int ROW_W    = 3,
  parameter int ROW_BITS = 8
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             cfg_we,
  input logic                             cfg_plane,
  input logic [ROW_W-1:0]                 cfg_row,
  input logic [ROW_BITS-1:0]              cfg_data,
  input logic [N_OUT-1:0]                 data_out,
  input logic [N_PT-1:0][2*N_IN-1:0]      and_mask,
  input logic [N_OUT-1:0][N_PT-1:0]       or_mask,
  input logic [N_PT-1:0]                  pt_vec
);
  localparam int AND_W = 2 * N_IN;

  function automatic logic self_contra(input logic [AND_W-1:0] m);
    logic r = 1'b0;
    for (int i = 0; i < N_IN; i++) r |= (m[2*i] & m[2*i+1]);
    return r;
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (data_out == '0 && and_mask == '0 && or_mask == '0)); // R8

  AST_HOLD_WITHOUT_WE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we) |=> ($stable(and_mask) && $stable(or_mask))); // R6

  AST_AND_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_plane && int'(cfg_row) >= N_PT) |=> $stable(and_mask)); // R7

  AST_OR_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_plane && int'(cfg_row) >= N_OUT) |=> $stable(or_mask)); // R7

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    AST_EMPTY_TERM_ONE: assert property (@(posedge clk) disable iff (rst)
      (and_mask[p] == '0) |-> pt_vec[p]); // R3
    AST_CONTRA_TERM_ZERO: assert property (@(posedge clk) disable iff (rst)
      self_contra(and_mask[p]) |-> !pt_vec[p]); // R5
    AST_AND_ROW_LANDS: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && !cfg_plane && cfg_row == ROW_W'(p))
      |=> (and_mask[p] == $past(cfg_data[AND_W-1:0]))); // R6
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    AST_EMPTY_SUM_ZERO: assert property (@(posedge clk) disable iff (rst)
      (or_mask[o] == '0) |-> !data_out[o]); // R4
    AST_OR_ROW_LANDS: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_plane && cfg_row == ROW_W'(o))
      |=> (or_mask[o] == $past(cfg_data[N_PT-1:0]))); // R6
  end
endmodule

bind lar_top lar_checker #(
  .N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT), .ROW_W(ROW_W), .ROW_BITS(ROW_BITS)
) u_lar_checker (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
  .cfg_row(cfg_row), .cfg_data(cfg_data), .data_out(data_out),
  .and_mask(and_mask), .or_mask(or_mask), .pt_vec(pt_vec)
);

// File: tb/lar_top_tb.sv
module lar_top_tb_top;
  localparam int N_IN     = 4;
  localparam int N_PT     = 6;
  localparam int N_OUT    = 3;
  localparam int AND_W    = 2 * N_IN;
  localparam int ROW_BITS = 8;
  localparam int ROW_W    = 3;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                cfg_we = 1'b0;
  logic                cfg_plane = 1'b0;
  logic [ROW_W-1:0]    cfg_row = '0;
  logic [ROW_BITS-1:0] cfg_data = '0;
  logic [N_IN-1:0]     data_in = '0;
  logic [N_OUT-1:0]    data_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [AND_W-1:0] m_and [N_PT];
  logic [N_PT-1:0]  m_or  [N_OUT];

  always #4 clk = ~clk;

  lar_top #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
    .cfg_row(cfg_row), .cfg_data(cfg_data), .data_in(data_in), .data_out(data_out)
  );

  function automatic logic [N_OUT-1:0] model(input logic [N_IN-1:0] v);
    logic [N_OUT-1:0] r = '0;
    for (int p = 0; p < N_PT; p++) begin
      logic t = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (m_and[p][2*i]   && !v[i]) t = 1'b0;
        if (m_and[p][2*i+1] &&  v[i]) t = 1'b0;
      end
      for (int o = 0; o < N_OUT; o++)
        if (m_or[o][p] && t) r[o] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [N_OUT-1:0] got, input logic [N_OUT-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s in=%b got=%b exp=%b", tag, data_in, got, exp);
    end
  endtask

  task automatic clear_model();
    for (int p = 0; p < N_PT; p++) m_and[p] = '0;
    for (int o = 0; o < N_OUT; o++) m_or[o] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); clear_model();
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic cfg_write(input logic plane, input int row, input logic [ROW_BITS-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_plane = plane; cfg_row = row[ROW_W-1:0]; cfg_data = d;
    @(posedge clk);
    if (!plane && row < N_PT) m_and[row] = d[AND_W-1:0];
    if (plane && row < N_OUT) m_or[row] = d[N_PT-1:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < (1 << N_IN); v++) begin
      data_in = v[N_IN-1:0];
      #1;
      check(tag, data_out, model(data_in));
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R8 R4: cleared maps give all-zero outputs
    sweep("R8 reset state");

    // R9 R1 R2: reference map, A=in0 B=in1 C=in2
    cfg_write(1'b0, 0, 8'h0A);  // A'B'
    cfg_write(1'b0, 1, 8'h21);  // AC'
    cfg_write(1'b0, 2, 8'h04);  // B
    cfg_write(1'b0, 3, 8'h24);  // BC'
    cfg_write(1'b0, 4, 8'h11);  // AC
    cfg_write(1'b1, 0, 8'h03);  // out0 = A'B' + AC'
    cfg_write(1'b1, 1, 8'h14);  // out1 = B + AC
    cfg_write(1'b1, 2, 8'h0A);  // out2 = AC' + BC' (AC' shared)
    for (int v = 0; v < 16; v++) begin
      logic a, b, c;
      data_in = v[3:0];
      a = v[0]; b = v[1]; c = v[2];
      #1;
      check("R9 out0", {2'b00, data_out[0]}, {2'b00, (~a & ~b) | (a & ~c)});
      check("R2 shared term", data_out, {(a & ~c) | (b & ~c), b | (a & c), (~a & ~b) | (a & ~c)});
    end

    // R3: empty product term is constant 1
    cfg_write(1'b1, 2, 8'h20);
    sweep("R3 empty term");
    // R5: A and A' together give constant 0
    cfg_write(1'b0, 5, 8'h03);
    sweep("R5 contradiction");

    // R6: strobe low, other config inputs busy
    @(negedge clk);
    cfg_plane = 1'b0; cfg_row = 3'd0; cfg_data = 8'hFF;
    repeat (3) @(negedge clk);
    cfg_plane = 1'b1; cfg_row = 3'd1; cfg_data = 8'h00;
    repeat (3) @(negedge clk);
    sweep("R6 no write");

    // R7: out-of-range rows and stray high bits
    cfg_write(1'b0, 6, 8'hFF);
    cfg_write(1'b0, 7, 8'h00);
    cfg_write(1'b1, 3, 8'h3F);
    cfg_write(1'b1, 7, 8'h00);
    sweep("R7 row range");
    cfg_write(1'b1, 0, 8'hC1);
    sweep("R7 high bits");

    // R10: input change seen within one cycle, no edge in between
    @(posedge clk); #1;
    data_in = 4'b0000; #1;
    check("R10 comb path", data_out, model(data_in));
    data_in = 4'b0001; #1;
    check("R10 comb path", data_out, model(data_in));

    // R1 R2: random maps
    for (int k = 0; k < 20; k++) begin
      for (int p = 0; p < N_PT; p++) cfg_write(1'b0, p, 8'($urandom));
      for (int o = 0; o < N_OUT; o++) cfg_write(1'b1, o, 8'($urandom));
      sweep("R1 R2 random map");
    end

    // R8: reset mid-run
    do_reset();
    sweep("R8 mid-run reset");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule